// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks an SDRAM controller through its power-up ritual without any software help. A single start pulse makes it latch the two bank-group configuration words and the timing word. It then presents the timing word to the controller with its refresh-enable field forced to zero, so the refresh engine stays quiet during bring-up. Next it issues a NOP, waits out the power-up settle time and replays a fixed command list, keeping a minimum gap between the commands. The list is one precharge, eight auto-refreshes and one mode-register set.

Every command in the list carries mode-register data in a dedicated field. The sequencer derives this data from the configured CAS latency and the data-bus width. A nonzero override value replaces the derived data. Once the mode-register set has been issued and one more gap has elapsed, the full timing word is restored (refresh on) and `done_o` rises. Both delays are cycle counts computed from the clock frequency, rounding up.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, all outputs are zero: configuration outputs, command word, valid strobe, refresh enable and done.
- R2: On an accepted start, `bank0_cfg_o`/`bank1_cfg_o` take the input words, and `timing_cfg_o` takes the timing word with its 2-bit refresh field (bits [REF_LSB+1:REF_LSB], default [4:3]) cleared. `refresh_en_o` stays low until the sequence ends.
- R3: The first command is a NOP, issued on the clock edge after the one that accepts start. Its command word is all zeros: operation code 0 in bits [1:0] and no mode data.
- R4: After the NOP comes a list of exactly ten commands: precharge (code 1), eight auto-refreshes (code 2) and a mode-register set (code 3), in that order.
- R5: The first list command follows the NOP by exactly PWR_CYC cycles, where PWR_CYC = ceil(PWRUP_NS * CLK_HZ / 1e9).
- R6: Consecutive list commands are exactly GAP_CYC = ceil(GAP_NS * CLK_HZ / 1e9) cycles apart (minimum 1).
- R7: `cmd_valid_o` is high for exactly one cycle per command. `cmd_word_o` is zero whenever `cmd_valid_o` is low.
- R8: The derived mode data is chosen by CAS latency and bus width. CAS latency is timing bits [2:0]: the value 2 means CL2, and every other value means CL3. Bus width is bank-0 bit 9: 1 means 32-bit, 0 means 16-bit. The four values are 0x40 (CL2, 32-bit), 0x60 (CL3, 32-bit), 0x20 (CL2, 16-bit) and 0x30 (CL3, 16-bit).
- R9: The 8-bit mode data occupies `cmd_word_o` bits [9:2] of every list command and is OR-ed with the operation code.
- R10: A nonzero `mode_override_i` at start is used as the mode data in place of the derived value.
- R11: Exactly GAP_CYC cycles after the mode-register set, `done_o` and `refresh_en_o` rise together and `timing_cfg_o` becomes the full latched timing word.
- R12: Start is ignored while a sequence is running, and so are changes to the configuration inputs. A start after done begins a new sequence and drops done and refresh enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin initialization (sampled when idle or done) |
| bank0_cfg_i | input | CFG_W | Bank group 0 configuration word |
| bank1_cfg_i | input | CFG_W | Bank group 1 configuration word |
| timing_cfg_i | input | CFG_W | Timing configuration word |
| mode_override_i | input | 8 | Mode data override, zero = derive |
| bank0_cfg_o | output | CFG_W | Latched bank group 0 configuration |
| bank1_cfg_o | output | CFG_W | Latched bank group 1 configuration |
| timing_cfg_o | output | CFG_W | Timing word presented to the controller |
| cmd_word_o | output | CMD_W | Command code with merged mode data |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| refresh_en_o | output | 1 | Refresh engine enabled |
| done_o | output | 1 | Initialization complete |

## Verification
The bench sweeps all eight CAS-latency codes for both bus widths and adds two override values. That exposes a design that compares the whole timing word instead of its low three bits, or reads the wrong width bit, because it would emit the wrong mode field on every list command. Each run checks every cycle against the exact pulse schedule, so a counter that is off by one or a list that is too short or too long shows up as a pulse landing on the wrong cycle. A start pulse fired mid-wait with changed inputs catches a sequencer that restarts or re-samples its configuration. Back-to-back runs without reset catch stale done or refresh state after a restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NOP  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  localparam logic [1:0] OP_NOP = 2'd0;
  localparam logic [1:0] OP_PRE = 2'd1;
  localparam logic [1:0] OP_REF = 2'd2;
  localparam logic [1:0] OP_MRS = 2'd3;

  localparam int MODE_W   = 8;
  localparam int MODE_LSB = 2;

endpackage

// File: rtl/sdram_init_mode.sv
module sdram_init_mode
  import sdram_init_pkg::*;
(
  input  logic [2:0]        cas_code_i,
  input  logic              wide_bus_i,
  input  logic [MODE_W-1:0] override_i,
  output logic [MODE_W-1:0] mode_o
);

  logic              is_cl2;
  logic [MODE_W-1:0] narrow_val;
  logic [MODE_W-1:0] derived;

  always_comb begin
    is_cl2     = (cas_code_i == 3'd2);
    narrow_val = is_cl2 ? 8'h20 : 8'h30;
    // the 32-bit value is the 16-bit value shifted up by one
    derived    = wide_bus_i ? {narrow_val[MODE_W-2:0], 1'b0} : narrow_val;
    mode_o     = (override_i != '0) ? override_i : derived;
  end

endmodule

// File: rtl/sdram_init_delay.sv
module sdram_init_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmdlist.sv
module sdram_init_cmdlist
  import sdram_init_pkg::*;
#(
  parameter int NUM_REF = 8,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [1:0]       op_o
);

  localparam int LAST = NUM_REF + 1;

  always_comb begin
    if (idx_i == '0)                op_o = OP_PRE;
    else if (idx_i == IDX_W'(LAST)) op_o = OP_MRS;
    else                            op_o = OP_REF;
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PWRUP_NS  = 200_000,
  parameter int GAP_NS    = 80,
  parameter int NUM_REF   = 8,
  parameter int CFG_W     = 32,
  parameter int REF_LSB   = 3,
  parameter int WIDTH_BIT = 9,
  parameter int CMD_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CFG_W-1:0]     bank0_cfg_i,
  input  logic [CFG_W-1:0]     bank1_cfg_i,
  input  logic [CFG_W-1:0]     timing_cfg_i,
  input  logic [MODE_W-1:0]    mode_override_i,
  output logic [CFG_W-1:0]     bank0_cfg_o,
  output logic [CFG_W-1:0]     bank1_cfg_o,
  output logic [CFG_W-1:0]     timing_cfg_o,
  output logic [CMD_W-1:0]     cmd_word_o,
  output logic                 cmd_valid_o,
  output logic                 refresh_en_o,
  output logic                 done_o
);

  localparam longint NS_PER_S  = 64'd1_000_000_000;
  localparam longint PWR_L     = (longint'(PWRUP_NS) * longint'(CLK_HZ) + NS_PER_S - 1) / NS_PER_S;
  localparam longint GAP_L     = (longint'(GAP_NS) * longint'(CLK_HZ) + NS_PER_S - 1) / NS_PER_S;
  localparam int     PWR_CYC   = (PWR_L < 1) ? 1 : int'(PWR_L);
  localparam int     GAP_CYC   = (GAP_L < 1) ? 1 : int'(GAP_L);
  localparam int     CNT_MAX   = (PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC;
  localparam int     CNT_W     = $clog2(CNT_MAX + 1);
  localparam int     LIST_LEN  = NUM_REF + 2;
  localparam int     IDX_W     = $clog2(LIST_LEN + 1);
  localparam logic [CFG_W-1:0] REF_MASK = ~(CFG_W'(2'b11) << REF_LSB);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [MODE_W-1:0] mode_q, mode_calc;
  logic [CFG_W-1:0]  bank0_q, bank1_q, timing_q;
  logic [CFG_W-1:0]  tout_q, tout_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              vld_q, vld_d;
  logic              ref_q, ref_d;
  logic              done_q, done_d;
  logic              cfg_ld, tout_en;
  logic              dly_load, dly_expired;
  logic [CNT_W-1:0]  dly_val;
  logic [1:0]        list_op;

  sdram_init_mode u_mode (
    .cas_code_i (timing_cfg_i[2:0]),
    .wide_bus_i (bank0_cfg_i[WIDTH_BIT]),
    .override_i (mode_override_i),
    .mode_o     (mode_calc)
  );

  sdram_init_delay #(.CNT_W(CNT_W)) u_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (dly_load),
    .load_val_i (dly_val),
    .expired_o  (dly_expired)
  );

  sdram_init_cmdlist #(.NUM_REF(NUM_REF), .IDX_W(IDX_W)) u_list (
    .idx_i (idx_q),
    .op_o  (list_op)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tout_d   = tout_q;
    ref_d    = ref_q;
    done_d   = done_q;
    vld_d    = 1'b0;
    cmd_d    = '0;
    cfg_ld   = 1'b0;
    tout_en  = 1'b0;
    dly_load = 1'b0;
    dly_val  = '0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          cfg_ld  = 1'b1;
          tout_en = 1'b1;
          tout_d  = timing_cfg_i & REF_MASK;
          ref_d   = 1'b0;
          done_d  = 1'b0;
          state_d = ST_NOP;
        end
      end
      ST_NOP: begin
        vld_d    = 1'b1;
        cmd_d    = CMD_W'(OP_NOP);
        dly_load = 1'b1;
        dly_val  = CNT_W'(PWR_CYC - 1);
        idx_d    = '0;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (dly_expired) begin
          if (idx_q == IDX_W'(LIST_LEN)) begin
            tout_en = 1'b1;
            tout_d  = timing_q;
            ref_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            vld_d    = 1'b1;
            cmd_d    = CMD_W'(list_op) | (CMD_W'(mode_q) << MODE_LSB);
            idx_d    = idx_q + 1'b1;
            dly_load = 1'b1;
            dly_val  = CNT_W'(GAP_CYC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control and command registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
      vld_q   <= 1'b0;
      ref_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cmd_q   <= cmd_d;
      vld_q   <= vld_d;
      ref_q   <= ref_d;
      done_q  <= done_d;
    end
  end

  // configuration registers, loaded only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank0_q  <= '0;
      bank1_q  <= '0;
      timing_q <= '0;
      mode_q   <= '0;
    end else if (cfg_ld) begin
      bank0_q  <= bank0_cfg_i;
      bank1_q  <= bank1_cfg_i;
      timing_q <= timing_cfg_i;
      mode_q   <= mode_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tout_q <= '0;
    else if (tout_en) tout_q <= tout_d;
  end

  assign bank0_cfg_o  = bank0_q;
  assign bank1_cfg_o  = bank1_q;
  assign timing_cfg_o = tout_q;
  assign cmd_word_o   = cmd_q;
  assign cmd_valid_o  = vld_q;
  assign refresh_en_o = ref_q;
  assign done_o       = done_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int CFG_W   = 32,
  parameter int REF_LSB = 3,
  parameter int CMD_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CFG_W-1:0] timing_cfg_o,
  input logic [CMD_W-1:0] cmd_word_o,
  input logic             cmd_valid_o,
  input logic             refresh_en_o,
  input logic             done_o
);

  // R7: no stray command bits between strobes
  a_r7_idle_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> (cmd_word_o == '0));

  // R2: refresh field stays cleared while refresh is off
  a_r2_refresh_field_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en_o |-> (timing_cfg_o[REF_LSB +: 2] == 2'b00));

  // R11: no command is issued once refresh is on or done is up
  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (!done_o && !refresh_en_o));

  // R3: a NOP carries no mode data
  a_r3_nop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_word_o[1:0] == 2'd0) |-> (cmd_word_o[CMD_W-1:2] == '0));

  // R12: done persists until a new start
  a_r12_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> done_o);

  // R11: done and refresh enable move together
  a_r11_done_refresh_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> refresh_en_o);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .CFG_W   (32),
  .REF_LSB (3),
  .CMD_W   (12)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .timing_cfg_o (timing_cfg_o),
  .cmd_word_o   (cmd_word_o),
  .cmd_valid_o  (cmd_valid_o),
  .refresh_en_o (refresh_en_o),
  .done_o       (done_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int P   = 100;   // 2000 ns at 50 MHz
  localparam int G   = 4;     // 80 ns at 50 MHz
  localparam int END = 1 + P + 10 * G;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] b0_i, b1_i, t_i;
  logic [7:0]  ovr_i;
  logic [31:0] b0_o, b1_o, t_o;
  logic [11:0] cmd_w;
  logic        cmd_v, ref_en, done;

  int tests  = 0;
  int fails  = 0;

  sdram_init_seq #(.PWRUP_NS(2000)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .bank0_cfg_i     (b0_i),
    .bank1_cfg_i     (b1_i),
    .timing_cfg_i    (t_i),
    .mode_override_i (ovr_i),
    .bank0_cfg_o     (b0_o),
    .bank1_cfg_o     (b1_o),
    .timing_cfg_o    (t_o),
    .cmd_word_o      (cmd_w),
    .cmd_valid_o     (cmd_v),
    .refresh_en_o    (ref_en),
    .done_o          (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mode(input int cl, input bit w32, input logic [7:0] ovr);
    logic [7:0] m;
    if (ovr != 0) return ovr;
    if (cl == 2) m = w32 ? 8'h40 : 8'h20;
    else         m = w32 ? 8'h60 : 8'h30;
    return m;
  endfunction

  task automatic run_seq(input int cl, input bit w32, input logic [7:0] ovr, input bit mid_start);
    logic [31:0] tcfg, b0, b1;
    logic [7:0]  m;
    int          extra;
    tcfg  = 32'hA5A5_0160 | 32'h18 | 32'(cl);
    b0    = 32'h1234_0000 | (w32 ? 32'h200 : 32'h0) | 32'(cl);
    b1    = ~b0;
    m     = exp_mode(cl, w32, ovr);
    extra = 0;
    @(negedge clk);
    b0_i = b0; b1_i = b1; t_i = tcfg; ovr_i = ovr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= END; k++) begin
      bit          exp_v;
      logic [11:0] exp_w;
      int          j;
      @(negedge clk);
      exp_v = 1'b0;
      exp_w = '0;
      if (k == 1) exp_v = 1'b1;
      if (k >= 1 + P && k < END && ((k - 1 - P) % G) == 0) begin
        j     = (k - 1 - P) / G;
        exp_v = 1'b1;
        exp_w = 12'((j == 0) ? 1 : (j == 9) ? 3 : 2) | (12'(m) << 2);
      end
      if (k == 1) begin
        check(cmd_v && cmd_w == 12'h000, "R3 nop", {20'h0, cmd_w}, 32'h0);
        check(b0_o == b0 && b1_o == b1, "R2 bank latch", b0_o, b0);
        check(t_o == (tcfg & ~32'h18), "R2 refresh cleared", t_o, tcfg & ~32'h18);
        check(!ref_en && !done, "R12 restart clears done", {30'h0, ref_en, done}, 32'h0);
      end else if (exp_v) begin
        check(cmd_v && cmd_w == exp_w, "R4 R5 R6 R9 list command",
              {19'h0, cmd_v, cmd_w}, {19'h0, 1'b1, exp_w});
      end else if (cmd_v || cmd_w != 0) begin
        extra++;
      end
      if (k == END - 1)
        check(!done && !ref_en && t_o == (tcfg & ~32'h18), "R11 not early",
              {30'h0, ref_en, done}, 32'h0);
      if (mid_start && k == 50) begin
        start = 1'b1; b0_i = 32'h0; t_i = 32'h2; ovr_i = 8'h77;
      end
      if (mid_start && k == 51) start = 1'b0;
    end
    check(extra == 0, "R7 single pulses", extra, 0);
    check(done && ref_en, "R11 done and refresh", {30'h0, ref_en, done}, 32'h3);
    check(t_o == tcfg, "R11 full timing", t_o, tcfg);
    if (mid_start)
      check(b0_o == b0, "R12 start ignored mid run", b0_o, b0);
    repeat (3) @(negedge clk);
    check(done && !cmd_v, "R12 done holds", {30'h0, cmd_v, done}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    b0_i = '0; b1_i = '0; t_i = '0; ovr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(b0_o == 0 && b1_o == 0 && t_o == 0 && cmd_w == 0 && !cmd_v && !ref_en && !done,
          "R1 reset state", {28'h0, cmd_v, ref_en, done, 1'b0}, 32'h0);
    // R8: every CAS code with both bus widths
    for (int cl = 0; cl < 8; cl++) begin
      for (int w = 0; w < 2; w++) begin
        run_seq(cl, w[0], 8'h00, (cl == 5));
      end
    end
    // R10: override replaces the derived value
    run_seq(2, 1'b1, 8'h5A, 1'b0);
    run_seq(3, 1'b0, 8'h01, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule